// File: doc/BRIEF.md
# Processor Low-Power Mode Controller

This block is a state machine that moves a processor core between a running state and four reduced-power states: a light stop, a snoop-capable stop, a deep stop and a stop with the PLL off. While the core runs, software chooses the next state with a two-bit mode code. The controller then agrees the change with the system over a quiesce request/acknowledge pair. It raises `qreq` and keeps the unit clocks and the snoop logic alive until the system answers with `qack`. Only after that does it gate them.

In the light stop, instruction fetch and the unit clocks are halted. The timer clock, which covers the time base, the decrementer and the debug port, keeps running. If the system wants the core to snoop a bus operation, it withdraws `qack`. The controller then steps into the snoop-capable stop and turns on bus snooping. Once `qack` is back and `snoop_busy` is low, it returns to the light stop.

In the deep stop, snooping and every internal clock are off, but the PLL stays locked. From the deep stop only, software may ask for the PLL-off state, which drops the PLL enable request. A wake event ends any stop state except the PLL-off state and brings the core back to full run. The PLL-off state ends only through reset, so that the PLL is restarted and relocked by the power-on sequence.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: Reset (synchronous, active-low `rst_n`) forces the run state from any state. In the run state `timer_clk_en`, `fetch_clk_en`, `unit_clk_en`, `snoop_en` and `pll_en` are 1 and `qreq` is 0.
- R2: In the run state, mode code 2'b01 (light stop) raises `qreq` and clears `fetch_clk_en` one cycle later. `unit_clk_en`, `snoop_en`, `pll_en` and `timer_clk_en` stay 1 while the controller waits for `qack`, for as many cycles as `qack` stays low.
- R3: While waiting for the light stop, a high `qack` moves the controller into the light stop one cycle later. There `fetch_clk_en`, `unit_clk_en` and `snoop_en` are 0, while `timer_clk_en`, `pll_en` and `qreq` are 1. The unit clocks are never gated unless `qack` was high in the cycle before.
- R4: In the light stop, a low `qack` moves the controller one cycle later into the snoop-capable stop. There `snoop_en` is 1, `fetch_clk_en` and `unit_clk_en` are 0, and `qreq` stays 1. A high `qack` with `snoop_busy` low returns it to the light stop one cycle later.
- R5: In the snoop-capable stop, the controller stays there as long as `snoop_busy` is 1, even when `qack` is high.
- R6: In the run state, mode code 2'b10 (deep stop) raises `qreq` and clears `fetch_clk_en` while keeping the unit clocks and snooping on. A high `qack` then moves the controller to the deep stop, where only `pll_en` and `qreq` are 1.
- R7: Mode code 2'b11 (PLL-off) is honoured only in the deep stop, where it clears `pll_en` one cycle later. In the run state it is ignored and all outputs keep their run values.
- R8: A wake event (any bit of `wake_evt` high) in either quiesce-wait state, the light stop, the snoop-capable stop or the deep stop returns the controller to the run state one cycle later, with `qreq` low and all enables 1.
- R9: In the PLL-off state, wake events and mode codes are ignored. Only reset leaves it, and all outputs except `qreq` stay 0.
- R10: In the deep stop, changes on `qack` and `snoop_busy` are ignored and `snoop_en` stays 0.
- R11: Mode codes are acted on only in the run state, except for the PLL-off code in the deep stop. For example, the deep-stop code given during the light stop leaves the light-stop outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_req | input | 2 | Software mode code: 00 none, 01 light stop, 10 deep stop, 11 PLL-off |
| wake_evt | input | WAKE_W | Wake event lines; any high bit wakes the core |
| qack | input | 1 | System acknowledge of the quiesce request |
| snoop_busy | input | 1 | Bus snoop activity still in progress |
| timer_clk_en | output | 1 | Enable for time base, decrementer and debug clocks |
| fetch_clk_en | output | 1 | Enable for the instruction fetch clock |
| unit_clk_en | output | 1 | Enable for the execution and memory unit clocks |
| snoop_en | output | 1 | Enable for bus snooping |
| pll_en | output | 1 | Request to keep the PLL running |
| qreq | output | 1 | Quiesce request to the system |

## Verification
Every output is decoded from the state register alone. An input value present at a rising edge therefore shows up on the outputs just after that same edge, one cycle after it was driven, and never combinationally. The bench drives inputs shortly after a rising edge. A behavioural model in the bench advances on each rising edge from the same inputs. The outputs are compared with the model at the following falling edge, which is exactly one register stage after the stimulus. The multi-cycle cases, such as waiting on `qack` or a long `snoop_busy`, are held for several cycles so that each cycle is checked against the model.

// File: rtl/pmc_pkg.sv
// Package: shared types for the low-power mode controller.
// Assumes: a two-bit software mode code; state order has no external meaning.
package pmc_pkg;

    localparam int MODE_W = 2;

    // Software mode codes (values are part of the block's contract).
    typedef enum logic [MODE_W-1:0] {
        MODE_NONE    = 2'b00,
        MODE_NAP     = 2'b01,
        MODE_SLEEP   = 2'b10,
        MODE_PLL_OFF = 2'b11
    } pmc_mode_e;

    // Controller states.
    typedef enum logic [2:0] {
        ST_RUN     = 3'd0,
        ST_NAP_Q   = 3'd1,
        ST_NAP     = 3'd2,
        ST_DOZE    = 3'd3,
        ST_SLP_Q   = 3'd4,
        ST_SLEEP   = 3'd5,
        ST_PLL_OFF = 3'd6
    } pmc_state_e;

    // Output enable bundle.
    typedef struct packed {
        logic timer;
        logic fetch;
        logic unit;
        logic snoop;
        logic pll;
        logic qreq;
    } pmc_gate_t;

endpackage

// File: rtl/pmc_req_decode.sv
// Module: pmc_req_decode
// Turns the raw mode code and wake lines into one-hot intent flags.
// Assumes: inputs are already synchronous to clk.
module pmc_req_decode
    import pmc_pkg::*;
#(
    parameter int WAKE_W = 4
) (
    input  logic [MODE_W-1:0] mode_req,
    input  logic [WAKE_W-1:0] wake_evt,
    output logic              want_nap,
    output logic              want_sleep,
    output logic              want_pll_off,
    output logic              wake_any
);

    logic [WAKE_W:0] wake_chain;

    // Ripple OR over the wake lines, one stage per line.
    assign wake_chain[0] = 1'b0;
    for (genvar g = 0; g < WAKE_W; g++) begin : g_wake
        assign wake_chain[g+1] = wake_chain[g] | wake_evt[g];
    end
    assign wake_any = wake_chain[WAKE_W];

    // Decode the mode code into individual requests.
    always_comb begin
        want_nap     = 1'b0;
        want_sleep   = 1'b0;
        want_pll_off = 1'b0;
        case (pmc_mode_e'(mode_req))
            MODE_NAP:     want_nap     = 1'b1;
            MODE_SLEEP:   want_sleep   = 1'b1;
            MODE_PLL_OFF: want_pll_off = 1'b1;
            default:      ;
        endcase
    end

    // At most one request is decoded at a time.
    always_comb begin
        a_onehot_req_r11: assert ($countones({want_nap, want_sleep, want_pll_off}) <= 1);
    end

endmodule

// File: rtl/pmc_fsm.sv
// Module: pmc_fsm
// Holds the power state and applies the handshake and wake rules.
// Assumes: wake has priority over every other input in a stop state;
// the PLL-off state is left only through reset.
module pmc_fsm
    import pmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       want_nap,
    input  logic       want_sleep,
    input  logic       want_pll_off,
    input  logic       wake_any,
    input  logic       qack,
    input  logic       snoop_busy,
    output pmc_state_e state
);

    pmc_state_e state_nx;

    // Next-state selection.
    always_comb begin
        state_nx = state;
        case (state)
            ST_RUN: begin
                if (want_nap)        state_nx = ST_NAP_Q;
                else if (want_sleep) state_nx = ST_SLP_Q;
            end
            ST_NAP_Q: begin
                if (wake_any)  state_nx = ST_RUN;
                else if (qack) state_nx = ST_NAP;
            end
            ST_NAP: begin
                if (wake_any)   state_nx = ST_RUN;
                else if (!qack) state_nx = ST_DOZE;
            end
            ST_DOZE: begin
                if (wake_any)                 state_nx = ST_RUN;
                else if (qack && !snoop_busy) state_nx = ST_NAP;
            end
            ST_SLP_Q: begin
                if (wake_any)  state_nx = ST_RUN;
                else if (qack) state_nx = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (wake_any)          state_nx = ST_RUN;
                else if (want_pll_off) state_nx = ST_PLL_OFF;
            end
            ST_PLL_OFF: state_nx = ST_PLL_OFF;
            default:    state_nx = ST_RUN;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // Clocks are gated only after an acknowledge.
    p_gate_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_NAP, ST_SLEEP} && $past(state) inside {ST_NAP_Q, ST_SLP_Q})
        |-> $past(qack));

    // Wake returns any stop state except PLL-off to run.
    p_wake_to_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_any && state != ST_RUN && state != ST_PLL_OFF) |=> state == ST_RUN);

    // PLL-off is left only through reset.
    p_pll_off_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_PLL_OFF |=> state == ST_PLL_OFF);

    // Doze is held while a snoop is in progress.
    p_doze_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DOZE && snoop_busy && !wake_any) |=> state == ST_DOZE);

    // PLL-off is reached only from the deep stop.
    p_pll_off_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PLL_OFF && $past(state) != ST_PLL_OFF) |-> $past(state) == ST_SLEEP);

endmodule

// File: rtl/pmc_gate_decode.sv
// Module: pmc_gate_decode
// Maps the power state onto the clock, snoop, PLL and quiesce outputs.
// Assumes: purely a function of state, so outputs follow state in the same cycle.
module pmc_gate_decode
    import pmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  pmc_state_e state,
    output pmc_gate_t  gate
);

    // Per-state enable table.
    always_comb begin
        gate = '{timer: 1'b1, fetch: 1'b1, unit: 1'b1, snoop: 1'b1, pll: 1'b1, qreq: 1'b0};
        case (state)
            ST_RUN: ;
            ST_NAP_Q, ST_SLP_Q: begin
                gate.fetch = 1'b0;
                gate.qreq  = 1'b1;
            end
            ST_NAP: begin
                gate.fetch = 1'b0;
                gate.unit  = 1'b0;
                gate.snoop = 1'b0;
                gate.qreq  = 1'b1;
            end
            ST_DOZE: begin
                gate.fetch = 1'b0;
                gate.unit  = 1'b0;
                gate.qreq  = 1'b1;
            end
            ST_SLEEP: begin
                gate.timer = 1'b0;
                gate.fetch = 1'b0;
                gate.unit  = 1'b0;
                gate.snoop = 1'b0;
                gate.qreq  = 1'b1;
            end
            ST_PLL_OFF: begin
                gate.timer = 1'b0;
                gate.fetch = 1'b0;
                gate.unit  = 1'b0;
                gate.snoop = 1'b0;
                gate.pll   = 1'b0;
                gate.qreq  = 1'b1;
            end
            default: ;
        endcase
    end

    // Fetch never runs while a quiesce is requested.
    p_fetch_vs_qreq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        gate.fetch |-> !gate.qreq);

    // Snooping is off in the deep stop.
    p_sleep_no_snoop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SLEEP |-> !gate.snoop);

    // The PLL request drops only when leaving the deep stop.
    p_pll_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate.pll) |-> $past(state) == ST_SLEEP);

endmodule

// File: rtl/pwr_mode_ctrl.sv
// Module: pwr_mode_ctrl (top)
// Low-power mode controller: request decode, state machine, output decode.
// Assumes: all inputs synchronous to clk; reset is synchronous and active low.
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int WAKE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_req,
    input  logic [WAKE_W-1:0] wake_evt,
    input  logic              qack,
    input  logic              snoop_busy,
    output logic              timer_clk_en,
    output logic              fetch_clk_en,
    output logic              unit_clk_en,
    output logic              snoop_en,
    output logic              pll_en,
    output logic              qreq
);

    logic       want_nap, want_sleep, want_pll_off, wake_any;
    pmc_state_e state;
    pmc_gate_t  gate;

    pmc_req_decode #(.WAKE_W(WAKE_W)) u_req (
        .mode_req     (mode_req),
        .wake_evt     (wake_evt),
        .want_nap     (want_nap),
        .want_sleep   (want_sleep),
        .want_pll_off (want_pll_off),
        .wake_any     (wake_any)
    );

    pmc_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .want_nap     (want_nap),
        .want_sleep   (want_sleep),
        .want_pll_off (want_pll_off),
        .wake_any     (wake_any),
        .qack         (qack),
        .snoop_busy   (snoop_busy),
        .state        (state)
    );

    pmc_gate_decode u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .state (state),
        .gate  (gate)
    );

    // Drive the ports from the enable bundle.
    assign timer_clk_en = gate.timer;
    assign fetch_clk_en = gate.fetch;
    assign unit_clk_en  = gate.unit;
    assign snoop_en     = gate.snoop;
    assign pll_en       = gate.pll;
    assign qreq         = gate.qreq;

    // After reset release, the first cycle shows run outputs.
    p_reset_run_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (fetch_clk_en && unit_clk_en && pll_en && !qreq));

endmodule

// File: tb/pwr_mode_ctrl_tb_top.sv
// Bench: behavioural reference model compared with the outputs on every cycle.
module pwr_mode_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WAKE_W     = 4;

    // Model states (bench's own numbering).
    localparam int M_RUN = 0, M_NAPW = 1, M_NAP = 2, M_DOZE = 3,
                   M_SLPW = 4, M_SLP = 5, M_OFF = 6;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [1:0]        mode_req;
    logic [WAKE_W-1:0] wake_evt;
    logic              qack;
    logic              snoop_busy;
    logic              timer_clk_en, fetch_clk_en, unit_clk_en, snoop_en, pll_en, qreq;

    int    n_run  = 0;
    int    n_fail = 0;
    int    cycles = 0;
    int    ms     = M_RUN;
    bit    started = 1'b0;
    string tag    = "R1";

    pwr_mode_ctrl #(.WAKE_W(WAKE_W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_req     (mode_req),
        .wake_evt     (wake_evt),
        .qack         (qack),
        .snoop_busy   (snoop_busy),
        .timer_clk_en (timer_clk_en),
        .fetch_clk_en (fetch_clk_en),
        .unit_clk_en  (unit_clk_en),
        .snoop_en     (snoop_en),
        .pll_en       (pll_en),
        .qreq         (qreq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected {timer, fetch, unit, snoop, pll, qreq} per model state.
    function automatic logic [5:0] expect_out(int s);
        case (s)
            M_RUN:  return 6'b111110;
            M_NAPW: return 6'b101111;
            M_NAP:  return 6'b100011;
            M_DOZE: return 6'b100111;
            M_SLPW: return 6'b101111;
            M_SLP:  return 6'b000011;
            default: return 6'b000001;
        endcase
    endfunction

    // Reference model: advances on each rising edge.
    always @(posedge clk) begin
        started <= 1'b1;
        cycles  <= cycles + 1;
        if (!rst_n) ms <= M_RUN;
        else if (ms == M_RUN) begin
            if (mode_req == 2'b01)      ms <= M_NAPW;
            else if (mode_req == 2'b10) ms <= M_SLPW;
        end
        else if (ms == M_OFF) ms <= M_OFF;
        else if (wake_evt != 0) ms <= M_RUN;
        else if ((ms == M_NAPW) && qack) ms <= M_NAP;
        else if ((ms == M_SLPW) && qack) ms <= M_SLP;
        else if ((ms == M_NAP) && !qack) ms <= M_DOZE;
        else if ((ms == M_DOZE) && qack && !snoop_busy) ms <= M_NAP;
        else if ((ms == M_SLP) && (mode_req == 2'b11)) ms <= M_OFF;
    end

    // Compare at the falling edge, one register stage after the stimulus.
    always @(negedge clk) begin
        if (started) begin
            logic [5:0] got;
            got = {timer_clk_en, fetch_clk_en, unit_clk_en, snoop_en, pll_en, qreq};
            n_run++;
            if (got !== expect_out(ms)) begin
                n_fail++;
                $display("FAIL %s: outputs %b expected %b (model state %0d)",
                         tag, got, expect_out(ms), ms);
            end
        end
    end

    // Wait n rising edges, then step just past the edge.
    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cycles > 5000) begin
            n_fail++;
            $display("FAIL watchdog: cycles %0d expected below 5000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; mode_req = 2'b00; wake_evt = '0; qack = 1'b0; snoop_busy = 1'b0;
        tag = "R1";  cyc(3);
        rst_n = 1'b1; cyc(2);

        tag = "R7";  mode_req = 2'b11; cyc(2);         // PLL-off code ignored in run
        mode_req = 2'b00;

        tag = "R2";  mode_req = 2'b01; cyc(1);         // light stop request
        mode_req = 2'b00; cyc(3);                      // waiting for qack
        tag = "R3";  qack = 1'b1; cyc(2);              // enter light stop
        tag = "R11"; mode_req = 2'b10; cyc(2);         // ignored outside run
        mode_req = 2'b00;

        tag = "R4";  qack = 1'b0; cyc(2);              // drop into doze
        tag = "R5";  snoop_busy = 1'b1; qack = 1'b1; cyc(3);
        tag = "R4";  snoop_busy = 1'b0; cyc(2);        // back to light stop

        tag = "R8";  wake_evt = 4'b0010; qack = 1'b0; cyc(1);
        wake_evt = '0; cyc(2);

        tag = "R4";  mode_req = 2'b01; cyc(1);
        mode_req = 2'b00; qack = 1'b1; cyc(2);
        qack = 1'b0; cyc(2);
        tag = "R8";  wake_evt = 4'b1000; cyc(1);       // wake from doze
        wake_evt = '0; cyc(2);

        tag = "R6";  mode_req = 2'b10; cyc(1);
        mode_req = 2'b00; cyc(2);
        tag = "R8";  wake_evt = 4'b0001; cyc(1);       // wake while waiting
        wake_evt = '0; cyc(1);

        tag = "R6";  mode_req = 2'b10; cyc(1);
        mode_req = 2'b00; qack = 1'b1; cyc(2);
        tag = "R10"; qack = 1'b0; snoop_busy = 1'b1; cyc(3);
        snoop_busy = 1'b0;
        tag = "R8";  wake_evt = 4'b0100; cyc(1);       // wake from deep stop
        wake_evt = '0; cyc(2);

        tag = "R6";  mode_req = 2'b10; cyc(1);
        mode_req = 2'b00; qack = 1'b1; cyc(2);
        tag = "R7";  mode_req = 2'b11; cyc(1);         // PLL off
        mode_req = 2'b00; cyc(2);
        tag = "R9";  wake_evt = 4'b1111; cyc(2);       // wake ignored
        wake_evt = '0; mode_req = 2'b01; cyc(2);       // mode ignored
        mode_req = 2'b00;
        tag = "R1";  rst_n = 1'b0; cyc(2);             // only reset leaves
        rst_n = 1'b1; qack = 1'b0; cyc(3);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule